// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block is the core-side controller that carries one coprocessor instruction from issue to completion. On a start pulse it takes an operation kind, a start address and a register value, presents a first-phase request to the coprocessor and then follows the coprocessor's answer. The coprocessor answers in the same cycle as the request. It can ask the core to wait, refuse the instruction, ask for another word, or finish. Five kinds of operation are handled: an internal data operation, a register write to the coprocessor, a register read from it, a multi-word load into it, and a multi-word store from it.

While the coprocessor keeps answering busy, the sequencer spends one idle cycle after each busy answer and then asks again in busy phase. In each idle cycle it looks for a pending interrupt. If one is found, the coprocessor gets a single interrupt-phase request and the instruction is dropped without a trap. Loads and stores use post-indexed word addressing over a simple request/grant memory port. The start address is checked before anything is issued. A memory abort seen on any word is held and reported when the sequence ends. Every operation finishes with a one-cycle done pulse that carries a status code.

Top module: `cph_seq`

## Requirements
- R1: After reset the sequencer is idle: done is low, the coprocessor phase is 0 (none), mem_req is low and status reads 0.
- R2: A start pulse puts a first-phase request (phase code 1) on the coprocessor port in the next cycle. A data operation (op 0) answered with done (response 3) or increment (response 2) finishes with status 0 (ok), and done is high two cycles after the start edge.
- R3: Each busy answer (response 0) to a first-phase or busy-phase request is followed by one idle cycle with phase 0, and then by a busy-phase request (phase code 2). Each busy answer adds two cycles to the latency.
- R4: When an interrupt is pending in the idle cycle of a busy wait, the coprocessor sees exactly one interrupt-phase request (phase code 3) and the operation then ends with status 4 (interrupted) rather than a trap, four cycles after start if the first answer was busy.
- R5: The pending interrupt is chosen in priority order: the reset request first (int_kind 1), then the fast request if fiq_mask is low (int_kind 2), then the normal request if irq_mask is low (int_kind 3). A masked request does not break the busy wait.
- R6: A cannot answer (response 1) to a first-phase or busy-phase request ends the operation on the next cycle with status 1 (undefined-instruction trap).
- R7: A load (op 3) moves one word per granted memory cycle. The first word is at the start address, the address rises by 4 for each increment answer, and the memory read data goes to the coprocessor in a data-phase cycle (phase code 4).
- R8: A store (op 4) moves words the same way with mem_we high, and writes the coprocessor's data onto mem_wdata during each granted data-phase cycle.
- R9: A load or store whose start address has any bit set at or above bit LEGAL_AW, or a store whose start address lies below VEC_BYTES, ends one cycle after start with status 2 (internal abort). No coprocessor request and no memory request are made.
- R10: A register write (op 1) gives the coprocessor the register value in one data-phase cycle and ends at latency 3 plus two per busy answer. A register read (op 2) captures cp_rdata in its data-phase cycle, adds one idle cycle, returns the value on rd_data and ends at latency 4 plus two per busy answer.
- R11: A memory abort on any granted word does not stop the transfer. It is held, and the sequence ends with status 3 (data abort).
- R12: Done is high for exactly one cycle, in the cycle after the final word, final coprocessor cycle or trap, and the next start is accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| op | input | 3 | Operation: 0 data op, 1 write to coprocessor, 2 read from coprocessor, 3 load, 4 store |
| start_addr | input | AW | First word address for load/store |
| wr_data | input | DW | Register value for a write |
| rst_req | input | 1 | Reset request, highest priority |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Masks fiq_req when high |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Masks irq_req when high |
| cp_phase | output | 3 | Request phase: 0 none, 1 first, 2 busy, 3 interrupt, 4 data |
| cp_op | output | 3 | Operation kind of the current instruction |
| cp_wdata | output | DW | Data to coprocessor (register value or loaded word) |
| cp_rdata | input | DW | Data from coprocessor (read value or word to store) |
| cp_resp | input | 2 | Same-cycle answer: 0 busy, 1 cannot, 2 increment, 3 done |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_gnt | input | 1 | Memory grant; the word moves in a cycle with req and gnt |
| mem_abort | input | 1 | Memory abort, valid with gnt |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 undefined trap, 2 internal abort, 3 data abort, 4 interrupted |
| int_kind | output | 2 | Interrupt that dropped the operation: 0 none, 1 reset, 2 fast, 3 normal |
| rd_data | output | DW | Value returned by a register read |

## Verification
The properties assume that the coprocessor always returns a legal response code in the same cycle as its request, and that mem_abort only matters in a granted cycle. They also assume that the start address does not come within one word of the top of the address space while an increment answer is outstanding. The bench keeps to this with a coprocessor model that answers from counters of busy and data cycles seen since start, with a memory model that grants either every cycle or every other cycle, and with transfer addresses far from the top of the range. Interrupt and mask inputs are held steady for a whole operation, so the winner in the idle cycle is known before the start pulse.

// File: rtl/cph_pkg.sv
package cph_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_DATA  = 3'd4
  } cp_phase_e;

  typedef enum logic [1:0] {
    RS_BUSY = 2'd0,
    RS_CANT = 2'd1,
    RS_INC  = 2'd2,
    RS_DONE = 2'd3
  } cp_resp_e;

  typedef enum logic [2:0] {
    OP_DATA  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } cp_op_e;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_UNDEF  = 3'd1,
    ST_IABORT = 3'd2,
    ST_DABORT = 3'd3,
    ST_INTR   = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    IK_NONE  = 2'd0,
    IK_RESET = 2'd1,
    IK_FIQ   = 2'd2,
    IK_IRQ   = 2'd3
  } int_kind_e;

  function automatic logic is_mem_op(input logic [2:0] o);
    return (o == OP_LOAD) || (o == OP_STORE);
  endfunction

  // Fixed priority pick: reset, then unmasked fast, then unmasked normal.
  function automatic logic [1:0] pick_int(input logic r, input logic f,
                                          input logic fm, input logic i,
                                          input logic im);
    if (r)              return IK_RESET;
    else if (f && !fm)  return IK_FIQ;
    else if (i && !im)  return IK_IRQ;
    else                return IK_NONE;
  endfunction

endpackage

// File: rtl/cph_prio.sv
module cph_prio
  import cph_pkg::*;
(
  input  logic       rst_req,
  input  logic       fiq_req,
  input  logic       fiq_mask,
  input  logic       irq_req,
  input  logic       irq_mask,
  output logic       pending,
  output logic [1:0] kind
);
  assign kind    = pick_int(rst_req, fiq_req, fiq_mask, irq_req, irq_mask);
  assign pending = (kind != IK_NONE);
endmodule

// File: rtl/cph_addr.sv
module cph_addr #(
  parameter int AW        = 32,
  parameter int LEGAL_AW  = 26,
  parameter int VEC_BYTES = 32,
  parameter int STEP      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          exc_range,
  output logic          exc_vector
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] VEC_V  = AW'(VEC_BYTES);

  function automatic logic beyond_range(input logic [AW-1:0] a);
    return (a >> LEGAL_AW) != '0;
  endfunction

  function automatic logic in_vectors(input logic [AW-1:0] a);
    return a < VEC_V;
  endfunction

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + STEP_V;
  endfunction

  assign exc_range  = beyond_range(start_addr);
  assign exc_vector = in_vectors(start_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= start_addr;
    else if (step)  addr <= next_word(addr);
  end
endmodule

// File: rtl/cph_seq.sv
module cph_seq
  import cph_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LEGAL_AW  = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rst_req,
  input  logic          fiq_req,
  input  logic          fiq_mask,
  input  logic          irq_req,
  input  logic          irq_mask,
  output logic [2:0]    cp_phase,
  output logic [2:0]    cp_op,
  output logic [DW-1:0] cp_wdata,
  input  logic [DW-1:0] cp_rdata,
  input  logic [1:0]    cp_resp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_gnt,
  input  logic          mem_abort,
  output logic          done,
  output logic [2:0]    status,
  output logic [1:0]    int_kind,
  output logic [DW-1:0] rd_data
);
  localparam int WORD_BYTES = DW / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR, S_CCYC, S_ICYC, S_XFER, S_FIN
  } state_e;

  state_e        state_q;
  logic [2:0]    op_q;
  logic [DW-1:0] src_q;
  logic [DW-1:0] rd_q;
  logic [2:0]    status_q;
  logic [1:0]    kind_q;
  logic          dab_q;

  // Named internal events, used by the bound checker.
  logic          accept;
  logic          start_bad;
  logic          asking;
  logic          word_move;
  logic          addr_step;
  logic          int_pend;
  logic [1:0]    int_win;
  logic          exc_range;
  logic          exc_vector;

  cph_prio u_prio (
    .rst_req (rst_req),
    .fiq_req (fiq_req),
    .fiq_mask(fiq_mask),
    .irq_req (irq_req),
    .irq_mask(irq_mask),
    .pending (int_pend),
    .kind    (int_win)
  );

  cph_addr #(
    .AW       (AW),
    .LEGAL_AW (LEGAL_AW),
    .VEC_BYTES(VEC_BYTES),
    .STEP     (WORD_BYTES)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .start_addr(start_addr),
    .step      (addr_step),
    .addr      (mem_addr),
    .exc_range (exc_range),
    .exc_vector(exc_vector)
  );

  assign accept    = (state_q == S_IDLE) && start;
  assign start_bad = is_mem_op(op) &&
                     (exc_range || ((op == OP_STORE) && exc_vector));
  assign asking    = (state_q == S_FIRST) || (state_q == S_BUSY);
  assign word_move = (state_q == S_XFER) && mem_gnt;
  assign addr_step = word_move && (cp_resp == RS_INC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_DATA;
      src_q    <= '0;
      rd_q     <= '0;
      status_q <= ST_OK;
      kind_q   <= IK_NONE;
      dab_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          op_q   <= op;
          src_q  <= wr_data;
          dab_q  <= 1'b0;
          kind_q <= IK_NONE;
          if (start_bad) begin
            status_q <= ST_IABORT;
            state_q  <= S_FIN;
          end else begin
            status_q <= ST_OK;
            state_q  <= S_FIRST;
          end
        end
        S_FIRST, S_BUSY: begin
          case (cp_resp)
            RS_BUSY: state_q <= S_WAIT;
            RS_CANT: begin
              status_q <= ST_UNDEF;
              state_q  <= S_FIN;
            end
            default: begin
              case (op_q)
                OP_WRITE, OP_READ: state_q <= S_CCYC;
                OP_LOAD, OP_STORE: state_q <= S_XFER;
                default:           state_q <= S_FIN;
              endcase
            end
          endcase
        end
        S_WAIT: begin
          if (int_pend) begin
            kind_q  <= int_win;
            state_q <= S_INTR;
          end else begin
            state_q <= S_BUSY;
          end
        end
        S_INTR: begin
          status_q <= ST_INTR;
          state_q  <= S_FIN;
        end
        S_CCYC: begin
          if (op_q == OP_READ) begin
            rd_q    <= cp_rdata;
            state_q <= S_ICYC;
          end else begin
            state_q <= S_FIN;
          end
        end
        S_ICYC: state_q <= S_FIN;
        S_XFER: if (mem_gnt) begin
          if (mem_abort) dab_q <= 1'b1;
          if (cp_resp != RS_INC) begin
            status_q <= (dab_q || mem_abort) ? ST_DABORT : ST_OK;
            state_q  <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      S_FIRST: cp_phase = PH_FIRST;
      S_BUSY:  cp_phase = PH_BUSY;
      S_INTR:  cp_phase = PH_INTR;
      S_CCYC:  cp_phase = PH_DATA;
      S_XFER:  cp_phase = mem_gnt ? PH_DATA : PH_NONE;
      default: cp_phase = PH_NONE;
    endcase
  end

  assign cp_op     = op_q;
  assign cp_wdata  = (state_q == S_XFER) ? mem_rdata : src_q;
  assign mem_req   = (state_q == S_XFER);
  assign mem_we    = mem_req && (op_q == OP_STORE);
  assign mem_wdata = cp_rdata;
  assign done      = (state_q == S_FIN);
  assign status    = status_q;
  assign int_kind  = kind_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/cph_seq_chk.sv
module cph_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [2:0]    status,
  input logic [1:0]    int_kind,
  input logic          asking,
  input logic          addr_step
);
  // R3: a busy answer is followed by an idle cycle
  p_busy_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (asking && cp_resp == 2'd0) |=> (cp_phase == 3'd0 && !done));

  // R6: a refusal ends the operation with the undefined trap
  p_cant_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (asking && cp_resp == 2'd1) |=> (done && status == 3'd1));

  // R4: exactly one interrupt-phase request, then completion
  p_intr_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == 3'd3) |=> (cp_phase == 3'd0 && done && status == 3'd4));

  // R5: an interrupted end always names its winner
  p_intr_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> (int_kind != 2'd0));

  // R7: increment answer moves the address up by one word
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4)));

  // R7: data phase in a transfer only with a grant
  p_data_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |-> (cp_phase == 3'd0));

  // R9: internal abort comes with no request of any kind before it
  p_iabort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd2) |-> ($past(cp_phase) == 3'd0 && !$past(mem_req)));

  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cph_seq cph_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cp_phase (cp_phase),
  .cp_resp  (cp_resp),
  .mem_req  (mem_req),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .done     (done),
  .status   (status),
  .int_kind (int_kind),
  .asking   (asking),
  .addr_step(addr_step)
);

// File: tb/test_cph_seq.sv
`timescale 1ns/1ps
module test_cph_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] start_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rst_req = 0, fiq_req = 0, fiq_mask = 0, irq_req = 0, irq_mask = 0;
  logic [2:0]  cp_phase, cp_op, status;
  logic [31:0] cp_wdata, cp_rdata, mem_addr, mem_wdata, mem_rdata, rd_data;
  logic [1:0]  cp_resp, int_kind;
  logic        mem_req, mem_we, mem_gnt, mem_abort, done;

  // scenario configuration
  int          busy_cfg = 0;
  logic [1:0]  final_cfg = 2'd3;
  int          words_cfg = 1;
  logic        slow_gnt = 1'b0;
  logic [31:0] abort_at = 32'hFFFF_FFF0;

  // model state and log
  int          busy_used, data_used, n_words, n_intr, bad_data, n_req_pre, n_we;
  logic [31:0] first_addr, last_addr, seen_wdata;
  logic        gtog;
  int          checks = 0, failures = 0;
  int          lat;

  always #2 clk = ~clk;

  cph_seq i_cph_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .start_addr(start_addr),
    .wr_data(wr_data), .rst_req(rst_req), .fiq_req(fiq_req), .fiq_mask(fiq_mask),
    .irq_req(irq_req), .irq_mask(irq_mask), .cp_phase(cp_phase), .cp_op(cp_op),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_resp(cp_resp), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_gnt(mem_gnt), .mem_abort(mem_abort), .done(done), .status(status),
    .int_kind(int_kind), .rd_data(rd_data)
  );

  // coprocessor model: answers in the request cycle
  always_comb begin
    if (cp_phase == 3'd1 || cp_phase == 3'd2)
      cp_resp = (busy_used < busy_cfg) ? 2'd0 : final_cfg;
    else if (cp_phase == 3'd4)
      cp_resp = (data_used + 1 < words_cfg) ? 2'd2 : 2'd3;
    else
      cp_resp = 2'd3;
  end
  assign cp_rdata  = 32'h5100_0000 + 32'(data_used);
  // memory model
  assign mem_gnt   = mem_req && (!slow_gnt || gtog);
  assign mem_rdata = ~mem_addr;
  assign mem_abort = mem_gnt && (mem_addr == abort_at);

  always @(posedge clk) begin
    gtog <= ~gtog;
    if (start) begin
      busy_used <= 0; data_used <= 0; n_words <= 0; n_intr <= 0;
      bad_data <= 0; n_req_pre <= 0; n_we <= 0; seen_wdata <= '0;
    end else begin
      if ((cp_phase == 3'd1 || cp_phase == 3'd2) && cp_resp == 2'd0)
        busy_used <= busy_used + 1;
      if (cp_phase == 3'd3) n_intr <= n_intr + 1;
      if (cp_phase == 3'd4) begin
        data_used <= data_used + 1;
        if (!mem_req) seen_wdata <= cp_wdata;
      end
      if (mem_req && mem_gnt) begin
        if (n_words == 0) first_addr <= mem_addr;
        last_addr <= mem_addr;
        n_words <= n_words + 1;
        if (mem_we) begin
          n_we <= n_we + 1;
          if (mem_wdata != 32'h5100_0000 + 32'(data_used)) bad_data <= bad_data + 1;
        end else if (cp_wdata != ~mem_addr) bad_data <= bad_data + 1;
      end
    end
  end

  initial begin
    gtog = 1'b0;
    busy_used = 0; data_used = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // issue one operation; lat = edges from start edge until done seen
  task automatic go(input logic [2:0] o, input logic [31:0] a, input logic [31:0] src,
                    output logic [2:0] ph1);
    @(negedge clk);
    op = o; start_addr = a; wr_data = src; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ph1 = cp_phase;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL R12 watchdog actual=0x%0h expected=0x%0h", lat, 0);
    end
    @(negedge clk);
    check("R12 done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic cfg(input int b, input logic [1:0] f, input int w);
    busy_cfg = b; final_cfg = f; words_cfg = w;
    slow_gnt = 1'b0; abort_at = 32'hFFFF_FFF0;
    rst_req = 0; fiq_req = 0; fiq_mask = 0; irq_req = 0; irq_mask = 0;
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 phase", {29'd0, cp_phase}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 status", {29'd0, status}, 32'd0);
  endtask

  task automatic t_data_op();
    logic [2:0] p;
    cfg(0, 2'd3, 1);
    go(3'd0, 32'h0, 32'h0, p);
    check("R2 first phase", {29'd0, p}, 32'd1);
    check("R2 latency", lat, 2);
    check("R2 status ok", {29'd0, status}, 32'd0);
    cfg(3, 2'd2, 1);
    go(3'd0, 32'h0, 32'h0, p);
    check("R3 latency 3 busy", lat, 8);
    check("R3 busy count", busy_used, 3);
    check("R3 status ok", {29'd0, status}, 32'd0);
  endtask

  task automatic t_cant();
    logic [2:0] p;
    cfg(1, 2'd1, 1);
    go(3'd1, 32'h0, 32'h1234, p);
    check("R6 latency", lat, 4);
    check("R6 undef status", {29'd0, status}, 32'd1);
  endtask

  task automatic t_interrupts();
    logic [2:0] p;
    cfg(2, 2'd3, 1); irq_req = 1;
    go(3'd0, 32'h0, 32'h0, p);
    check("R4 latency", lat, 4);
    check("R4 interrupted status", {29'd0, status}, 32'd4);
    check("R4 one intr phase", n_intr, 1);
    check("R5 kind irq", {30'd0, int_kind}, 32'd3);
    cfg(2, 2'd3, 1); irq_req = 1; irq_mask = 1; fiq_req = 1; fiq_mask = 1;
    go(3'd0, 32'h0, 32'h0, p);
    check("R5 masked no break latency", lat, 6);
    check("R5 masked status", {29'd0, status}, 32'd0);
    cfg(1, 2'd3, 1); irq_req = 1; fiq_req = 1;
    go(3'd0, 32'h0, 32'h0, p);
    check("R5 fiq over irq", {30'd0, int_kind}, 32'd2);
    cfg(1, 2'd3, 1); irq_req = 1; fiq_req = 1; rst_req = 1; fiq_mask = 1;
    go(3'd0, 32'h0, 32'h0, p);
    check("R5 reset first", {30'd0, int_kind}, 32'd1);
    cfg(0, 2'd3, 1);
  endtask

  task automatic t_load();
    logic [2:0] p;
    cfg(1, 2'd3, 4);
    go(3'd3, 32'h100, 32'h0, p);
    check("R7 latency", lat, 8);
    check("R7 words", n_words, 4);
    check("R7 first addr", first_addr, 32'h100);
    check("R7 last addr", last_addr, 32'h10C);
    check("R7 data to cp", bad_data, 0);
    check("R7 status", {29'd0, status}, 32'd0);
    cfg(0, 2'd3, 3); slow_gnt = 1;
    go(3'd3, 32'h200, 32'h0, p);
    check("R7 slow grant words", n_words, 3);
    check("R7 slow grant last", last_addr, 32'h208);
    check("R7 slow grant data", bad_data, 0);
  endtask

  task automatic t_store();
    logic [2:0] p;
    cfg(0, 2'd3, 3);
    go(3'd4, 32'h2000, 32'h0, p);
    check("R8 latency", lat, 5);
    check("R8 write words", n_we, 3);
    check("R8 last addr", last_addr, 32'h2008);
    check("R8 data from cp", bad_data, 0);
  endtask

  task automatic t_iabort();
    logic [2:0] p;
    cfg(0, 2'd3, 2);
    go(3'd4, 32'h10, 32'h0, p);
    check("R9 vector store latency", lat, 1);
    check("R9 vector store status", {29'd0, status}, 32'd2);
    check("R9 no memory", n_words, 0);
    go(3'd3, 32'h0400_0000, 32'h0, p);
    check("R9 range status", {29'd0, status}, 32'd2);
    check("R9 range no cp request", {29'd0, p}, 32'd0);
    cfg(0, 2'd3, 1);
    go(3'd3, 32'h10, 32'h0, p);
    check("R9 load in vectors allowed", lat, 3);
    check("R9 load in vectors status", {29'd0, status}, 32'd0);
  endtask

  task automatic t_regs();
    logic [2:0] p;
    cfg(0, 2'd3, 1);
    go(3'd2, 32'h0, 32'h0, p);
    check("R10 read latency", lat, 4);
    check("R10 read data", rd_data, 32'h5100_0000);
    cfg(2, 2'd3, 1);
    go(3'd1, 32'h0, 32'hCAFE_0042, p);
    check("R10 write latency", lat, 7);
    check("R10 write data", seen_wdata, 32'hCAFE_0042);
  endtask

  task automatic t_dabort();
    logic [2:0] p;
    cfg(0, 2'd3, 3); abort_at = 32'h304;
    go(3'd3, 32'h300, 32'h0, p);
    check("R11 continues", n_words, 3);
    check("R11 data abort status", {29'd0, status}, 32'd3);
    cfg(0, 2'd3, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_op();
    t_cant();
    t_interrupts();
    t_load();
    t_store();
    t_iabort();
    t_regs();
    t_dabort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R12 global watchdog actual=0x%0h expected=0x%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule